// File: doc/BRIEF.md
# Flow-Controlled FIFO Burst Writer

This block drains a counted burst of 16-bit words from an on-chip source queue into an external synchronous FIFO. A start pulse loads a 32-bit word count. The sequencer then spends one cycle in an inactive state and moves on to a flow state. In the flow state the source queue's empty flag gates the transfer on every clock. While the source holds data, the active-low write strobe is driven low, the source word is placed on the output bus and the source is popped, so one word moves per clock. When the source is empty the strobe stays high and nothing moves.

The block leaves the flow state only through a separate decision on the transaction counter. The counter drops by one for every word moved. When it reaches zero the sequencer returns to idle, and it does so before another edge could capture a repeated word. The done output reads 1 whenever the engine is idle, so a controller can poll it before it launches a burst and again to see that the burst has finished.

Top module: `fifo_burst_writer`

## Requirements
- R1: After reset the state code is 7 (idle), done is 1, the write strobe is high and the pop strobe is low.
- R2: A start pulse seen in idle loads the count and enters the inactive state, code 0, for exactly one cycle with the write strobe high. The next state is the flow state, code 1, unless the count is zero.
- R3: In the flow state with the source empty flag at 0 and words remaining, the write strobe is low, the pop strobe is high and the data bus carries the source word in that same cycle.
- R4: In the flow state with the source empty flag at 1, the write strobe is high, the pop strobe is low and the remaining count does not change.
- R5: Exactly the loaded number of words is written. The cycle after the word that brings the count to zero shows state 7, with no further write strobe.
- R6: Done is 1 exactly in the cycles when the state code is 7.
- R7: A start pulse while the state is not idle is ignored. This includes the cycle of the final word. A start in the first idle cycle afterwards is accepted.
- R8: A start with a count of zero passes through the inactive state for one cycle and then returns to idle, without ever driving the write strobe low.
- R9: The pop strobe is high in exactly the cycles when the write strobe is low.
- R10: All 32 count bits take part in the transfer. A count of 0x0001_0000 moves 65536 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst launch pulse |
| count_i | input | 32 | Number of words in the burst, sampled with start |
| src_empty_i | input | 1 | Source queue empty flag |
| src_data_i | input | 16 | Word at the head of the source queue |
| src_pop_o | output | 1 | Removes the head word from the source |
| wr_n_o | output | 1 | Active-low write strobe to the external FIFO |
| wr_data_o | output | 16 | Data bus to the external FIFO |
| done_o | output | 1 | High while the engine is idle |
| state_o | output | 3 | Sequencer state code (0 inactive, 1 flow, 7 idle) |

## Verification
The final word and a new start pulse can fall in the same cycle. The bench provokes this by raising start exactly when one word remains and the source is not empty. It judges the result by checking that the state returns to 7 with no extra write, and that only a start raised in the following idle cycle launches the next burst. A second collision occurs between a source stall and the last remaining word. Stall patterns with different periods make the empty flag land on the final word, and the per-cycle reference model confirms that the strobe stays high until data returns.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  localparam int TC_W = 32;
  localparam int DW   = 16;

  typedef enum logic [2:0] {
    ST_INACT = 3'd0,
    ST_FLOW  = 3'd1,
    ST_IDLE  = 3'd7
  } fbw_state_e;

  // remaining count after one clock, given whether a word moved
  function automatic logic [TC_W-1:0] tc_next(input logic [TC_W-1:0] c, input logic moved);
    return c - {{(TC_W-1){1'b0}}, moved};
  endfunction

  // the word that moves now is the last of the burst
  function automatic logic is_last(input logic moved, input logic [TC_W-1:0] c);
    return moved && (c == {{(TC_W-1){1'b0}}, 1'b1});
  endfunction
endpackage

// File: rtl/fbw_tcount.sv
module fbw_tcount #(
  parameter int W = fbw_pkg::TC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= fbw_pkg::tc_next(cnt_q, dec_i);
  end

  assign count_o = cnt_q;
  assign zero_o  = (cnt_q == '0);
endmodule

// File: rtl/fbw_flow.sv
module fbw_flow (
  input  logic in_flow_i,
  input  logic src_empty_i,
  input  logic tc_zero_i,
  output logic move_o,
  output logic wr_n_o
);
  // flow condition is the empty flag; expiry masks any move
  always_comb begin
    move_o = in_flow_i && !src_empty_i && !tc_zero_i;
    wr_n_o = !move_o;
  end
endmodule

// File: rtl/fbw_sequencer.sv
module fbw_sequencer
  import fbw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       tc_zero_i,
  input  logic       last_word_i,
  output fbw_state_e state_o,
  output logic       load_o
);
  fbw_state_e st_q, st_d;

  assign load_o = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_INACT;
      ST_INACT: st_d = tc_zero_i ? ST_IDLE : ST_FLOW;
      ST_FLOW:  if (tc_zero_i || last_word_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/fifo_burst_writer.sv
module fifo_burst_writer
  import fbw_pkg::*;
#(
  parameter int CW = TC_W,
  parameter int WW = DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          src_empty_i,
  input  logic [WW-1:0] src_data_i,
  output logic          src_pop_o,
  output logic          wr_n_o,
  output logic [WW-1:0] wr_data_o,
  output logic          done_o,
  output logic [2:0]    state_o
);
  fbw_state_e    state;
  logic          load, move, tc_zero, last_word;
  logic [CW-1:0] tc;

  fbw_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tc_zero_i(tc_zero),
    .last_word_i(last_word), .state_o(state), .load_o(load)
  );

  fbw_tcount #(.W(CW)) u_tc (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(count_i),
    .dec_i(move), .count_o(tc), .zero_o(tc_zero)
  );

  fbw_flow u_flow (
    .in_flow_i(state == ST_FLOW), .src_empty_i(src_empty_i),
    .tc_zero_i(tc_zero), .move_o(move), .wr_n_o(wr_n_o)
  );

  assign last_word = is_last(move, tc);
  assign src_pop_o = move;
  assign wr_data_o = src_data_i;
  assign done_o    = (state == ST_IDLE);
  assign state_o   = state;

  // R2: the inactive state lasts one cycle
  a_r2_inact_once: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_INACT |=> state != ST_INACT);
  // R3: a pop never happens from an empty source
  a_r3_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop_o |-> !src_empty_i && state == ST_FLOW);
  // R4: a stall holds the counter
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLOW && src_empty_i) |=> $stable(tc));
  // R5: the final word is followed by idle
  a_r5_exit_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pop_o && tc == {{(CW-1){1'b0}}, 1'b1}) |=> state == ST_IDLE && wr_n_o);
  // R7: a start while busy does not reload
  a_r7_busy_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && start_i) |=> tc <= $past(tc));
  // R8: a zero count goes back to idle
  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INACT && tc_zero) |=> state == ST_IDLE);
endmodule

// File: tb/fifo_burst_writer_tb_top.sv
module fifo_burst_writer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] count = '0;
  logic src_empty = 1'b1;
  logic [15:0] src_data = '0;
  logic pop, wr_n, done;
  logic [15:0] wr_data;
  logic [2:0] state;

  int checks = 0;
  int fails = 0;
  int mode = 7;          // model state code
  longint rem = 0;       // model remaining words
  logic [15:0] next_word = 16'h1000;
  longint burst_writes = 0;

  always #2 clk = ~clk;

  fifo_burst_writer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .count_i(count),
    .src_empty_i(src_empty), .src_data_i(src_data), .src_pop_o(pop),
    .wr_n_o(wr_n), .wr_data_o(wr_data), .done_o(done), .state_o(state)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input string tag, input logic ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // one clock: drive, compare against the model, advance the model
  task automatic step(input string tag, input logic st, input logic [31:0] cnt, input logic emp);
    logic exp_move;
    logic [15:0] exp_data, act_data;
    @(negedge clk);
    start = st; count = cnt; src_empty = emp; src_data = next_word;
    #1;
    exp_move = (mode == 1) && !emp && rem != 0;
    exp_data = exp_move ? next_word : 16'h0;
    act_data = exp_move ? wr_data : 16'h0;
    check(tag,
      state == mode[2:0] && wr_n == !exp_move && pop == exp_move &&
      act_data == exp_data && done == (mode == 7),
      $sformatf("st=%0d wr_n=%b pop=%b d=%h done=%b", state, wr_n, pop, act_data, done),
      $sformatf("st=%0d wr_n=%b pop=%b d=%h done=%b", mode, !exp_move, exp_move, exp_data, mode == 7));
    case (mode)
      7: if (st) begin mode = 0; rem = cnt; burst_writes = 0; end
      0: mode = (rem == 0) ? 7 : 1;
      default: if (exp_move) begin
        rem--; burst_writes++; next_word = next_word + 16'h1;
        if (rem == 0) mode = 7;
      end
    endcase
  endtask

  // stall_per: 0 no stalls, else empty on every stall_per-th cycle
  task automatic run_burst(input string tag, input longint n, input int stall_per,
                           input logic start_on_last);
    int i = 0;
    logic e;
    step(tag, 1'b1, n[31:0], 1'b0);
    while (mode != 7) begin
      e = (stall_per > 0) && (i % stall_per == stall_per - 1);
      if (start_on_last && mode == 1 && rem == 1 && !e)
        step("R7 start on final word", 1'b1, 32'd3, e);
      else if (i == 6)
        step("R7 start while busy", 1'b1, 32'd99, e);
      else
        step(tag, 1'b0, 32'd0, e);
      i++;
    end
    check({tag, " R5 word total"}, burst_writes == n,
          $sformatf("%0d", burst_writes), $sformatf("%0d", n));
    step("R6 idle after burst", 1'b0, 32'd0, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R5: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    step("R1 reset state", 1'b0, 32'd0, 1'b0);
    step("R1 reset state", 1'b0, 32'd0, 1'b1);
    run_burst("R3 R2 burst of 32", 32, 0, 1'b0);
    run_burst("R4 R9 stalled burst of 256", 256, 5, 1'b0);
    run_burst("R4 stall on odd period", 13, 3, 1'b0);
    run_burst("R7 collision burst", 8, 0, 1'b1);
    step("R7 start after last accepted", 1'b1, 32'd3, 1'b0);
    while (mode != 7) step("R7 follow-on burst", 1'b0, 32'd0, 1'b0);
    check("R7 follow-on total", burst_writes == 3, $sformatf("%0d", burst_writes), "3");
    step("R8 zero count start", 1'b1, 32'd0, 1'b0);
    step("R8 zero count inactive", 1'b0, 32'd0, 1'b0);
    step("R8 zero count back to idle", 1'b0, 32'd0, 1'b0);
    run_burst("R3 single word", 1, 0, 1'b0);
    run_burst("R10 upper count bit", 64'h0001_0000, 0, 1'b0);
    summary();
    $finish;
  end
endmodule